// File: doc/BRIEF.md
# Ping-Pong Block Bit Interleaver

This block reorders the bits of a serial coded stream in fixed blocks of 64. Two single-bit storage banks alternate roles. One bank takes incoming bits at consecutive addresses. The other bank, which holds the previously completed block, is read out through a 64-entry read-address table, so its bits leave in permuted order. A one-bit mode input selects the address table. The forward table spreads a 4-row by 16-column arrangement. The inverse table swaps the roles of rows and columns and restores the original order. The same hardware therefore serves the transmit path and the receive path.

Reading is paced by the input strobe. Each valid input bit also pulls one bit from the draining bank, so the output rate equals the input rate and no bank can overflow. The first permuted block starts to appear once 64 valid bits have been accepted after reset. After that, a stream with no gaps leaves the block as a stream with no gaps, delayed by one block plus one cycle.

Top module: `bit_interleaver_pp`

## Requirements
- R1: A synchronous reset (`rst` high) clears all counters and marks both banks empty. `out_valid` is low in the cycle after reset. No output appears until 64 further valid bits have been accepted.
- R2: Within a block, the k-th valid input bit (k = 0..63, counted from the block start) is stored at bank address k.
- R3: With mode 0 (forward), output j (j = 0..63) of a block is the stored bit at address (j mod 4)*16 + floor(j/4).
- R4: With mode 1 (inverse), output j of a block is the stored bit at address (j mod 16)*4 + floor(j/16).
- R5: The banks exchange write and read roles exactly on the valid input that completes 64 written bits, and on no other cycle.
- R6: `out_valid` is high exactly one cycle after a cycle in which `in_valid` was high while a completed block was draining. Each such input yields exactly one output bit.
- R7: A cycle with `in_valid` low changes no counter, and `out_valid` is low in the following cycle.
- R8: The table used to read a block is selected by the `mode` value present on the valid input that completes that block.
- R9: Under continuous input, the last read of one block and the first read of the next happen on consecutive valid cycles. No bit is lost or repeated across the bank swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = forward table, 1 = inverse table |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit strobe |
| out_bit | output | 1 | Serial permuted output bit |

## Verification
The 64th write into one bank, the last read of the other bank, the role exchange and the capture of the mode for the next read all fall in the same cycle. The bench provokes this by streaming blocks back to back with no gaps. It also places idle cycles and a mode change right at the final bit of a block. A behavioural model built on queued blocks predicts every output bit and strobe on every clock. A bit lost, repeated or taken from the wrong table at the swap shows up as a mismatch in the first or last output positions.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic {
      ILV_FWD = 1'b0,
      ILV_INV = 1'b1
   } ilv_mode_e;

   // forward permutation: position k leaves from row-major cell of a ROWS x COLS grid
   function automatic int unsigned ilv_fwd_addr(input int unsigned k,
                                                input int unsigned rows,
                                                input int unsigned cols);
      return (k % rows) * cols + (k / rows);
   endfunction

   // inverse permutation: rows and columns interchanged
   function automatic int unsigned ilv_inv_addr(input int unsigned k,
                                                input int unsigned rows,
                                                input int unsigned cols);
      return (k % cols) * rows + (k / cols);
   endfunction

endpackage

// File: rtl/ilv_addr_table.sv
module ilv_addr_table
   import ilv_pkg::*;
#(
   parameter int ROWS       = 4,
   parameter int COLS       = 16,
   parameter bit FROM_TABLE = 1'b1,
   localparam int N  = ROWS * COLS,
   localparam int AW = $clog2(N)
) (
   input  logic [AW-1:0] idx,
   input  ilv_mode_e     mode,
   output logic [AW-1:0] addr
);
   localparam int RB = $clog2(ROWS);
   localparam int CB = $clog2(COLS);

   generate
      if (FROM_TABLE) begin : g_table
         logic [AW-1:0] fwd_rom [N];
         logic [AW-1:0] inv_rom [N];
         for (genvar k = 0; k < N; k++) begin : g_entry
            assign fwd_rom[k] = AW'(ilv_fwd_addr(k, ROWS, COLS));
            assign inv_rom[k] = AW'(ilv_inv_addr(k, ROWS, COLS));
         end
         assign addr = (mode == ILV_INV) ? inv_rom[idx] : fwd_rom[idx];
      end else begin : g_arith
         // power-of-two grid: the permutation is a rotation of index bits
         logic [AW-1:0] fwd_a, inv_a;
         assign fwd_a = {idx[RB-1:0], idx[AW-1:RB]};
         assign inv_a = {idx[CB-1:0], idx[AW-1:CB]};
         assign addr  = (mode == ILV_INV) ? inv_a : fwd_a;
      end
   endgenerate

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);
   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wbit;
   end

   assign rbit = cells[raddr];

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
   import ilv_pkg::*;
#(
   parameter int N = 64,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  ilv_mode_e     mode,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          wsel,
   output logic          rd_en,
   output logic [AW-1:0] rd_idx,
   output ilv_mode_e     rd_mode
);
   localparam logic [AW-1:0] LAST = AW'(N - 1);

   logic [AW-1:0] wr_cnt, rd_cnt;
   logic          wsel_q, live_q;
   ilv_mode_e     mode_q;
   logic          blk_done;

   assign blk_done = in_valid && (wr_cnt == LAST);
   assign wr_en    = in_valid;
   assign wr_addr  = wr_cnt;
   assign wsel     = wsel_q;
   assign rd_en    = in_valid && live_q;
   assign rd_idx   = rd_cnt;
   assign rd_mode  = mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_cnt <= '0;
         rd_cnt <= '0;
         wsel_q <= 1'b0;
         live_q <= 1'b0;
         mode_q <= ILV_FWD;
      end else if (in_valid) begin
         wr_cnt <= blk_done ? '0 : wr_cnt + 1'b1;
         if (live_q) rd_cnt <= (rd_cnt == LAST) ? '0 : rd_cnt + 1'b1;
         if (blk_done) begin
            wsel_q <= ~wsel_q;
            live_q <= 1'b1;
            mode_q <= mode;
            rd_cnt <= '0;
         end
      end
   end

   AST_SWAP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
      blk_done |=> (wsel_q != $past(wsel_q)) && (wr_cnt == '0) && live_q); // R5
   AST_NO_EARLY_SWAP: assert property (@(posedge clk) disable iff (rst)
      !blk_done |=> $stable(wsel_q)); // R5
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(wr_cnt) && $stable(rd_cnt)); // R7
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
      !blk_done |=> $stable(mode_q)); // R8
   AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
      live_q |-> (rd_cnt == wr_cnt)); // R9

endmodule

// File: rtl/bit_interleaver_pp.sv
module bit_interleaver_pp
   import ilv_pkg::*;
#(
   parameter int ROWS       = 4,
   parameter int COLS       = 16,
   parameter bit FROM_TABLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   localparam int N  = ROWS * COLS;
   localparam int AW = $clog2(N);

   generate
      if (ROWS < 2 || COLS < 2) begin : g_bad_dim
         $error("grid needs at least 2 rows and 2 columns");
      end
      if ((1 << $clog2(ROWS)) != ROWS || (1 << $clog2(COLS)) != COLS) begin : g_bad_pow
         $error("rows and columns must be powers of two");
      end
   endgenerate

   logic          wr_en, wsel, rd_en, rsel, rbit;
   logic [AW-1:0] wr_addr, rd_idx, rd_addr;
   ilv_mode_e     rd_mode;
   logic [1:0]    bank_rbit;

   ilv_ctrl #(.N(N)) i_ctrl (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .mode    (ilv_mode_e'(mode)),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wsel    (wsel),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_mode (rd_mode)
   );

   ilv_addr_table #(.ROWS(ROWS), .COLS(COLS), .FROM_TABLE(FROM_TABLE)) i_table (
      .idx (rd_idx),
      .mode(rd_mode),
      .addr(rd_addr)
   );

   assign rsel = ~wsel;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      ilv_bank #(.DEPTH(N)) i_bank (
         .clk  (clk),
         .we   (wr_en && (wsel == 1'(b))),
         .waddr(wr_addr),
         .wbit (in_bit),
         .raddr(rd_addr),
         .rbit (bank_rbit[b])
      );
   end

   assign rbit = bank_rbit[rsel];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= rd_en;
         if (rd_en) out_bit <= rbit;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !out_valid); // R1
   AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid)); // R6
   AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R7

endmodule

// File: tb/test_bit_interleaver_pp.sv
module test_bit_interleaver_pp;

   logic clk = 1'b0;
   logic rst, mode, in_valid, in_bit;
   logic out_valid, out_bit;

   int total = 0;
   int bad   = 0;

   // behavioural reference state
   bit cur_blk [64];
   bit done_q  [$];
   bit pend_mode;
   bit live;
   int wcnt, rcnt;
   bit drain_blk [64];
   bit drain_mode;

   always #5 clk = ~clk;

   bit_interleaver_pp i_bit_interleaver_pp (
      .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
      .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit)
   );

   function automatic int ref_addr(input bit m, input int j);
      if (m) return (j % 16) * 4 + j / 16;   // R4
      return (j % 4) * 16 + j / 4;            // R3
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      live = 0; wcnt = 0; rcnt = 0; pend_mode = 0;
   endtask

   // one clock: apply inputs, predict, compare after the edge
   task automatic step(input bit v, input bit b, input bit m);
      bit exp_v, exp_b;
      string tag;
      exp_v = v && live;
      exp_b = 1'b0;
      if (exp_v) begin
         exp_b = drain_blk[ref_addr(drain_mode, rcnt)];
         rcnt++;
      end
      if (v) begin
         cur_blk[wcnt] = b;   // R2 sequential write
         wcnt++;
         if (wcnt == 64) begin   // R5 swap on the 64th bit, R8 mode capture
            drain_blk  = cur_blk;
            drain_mode = m;
            live = 1; wcnt = 0; rcnt = 0;
         end
      end
      in_valid = v; in_bit = b; mode = m;
      @(posedge clk); #1;
      tag = !v ? "R7" : (exp_v ? "R6" : "R1");
      check(tag, out_valid, exp_v);
      if (exp_v) check(drain_mode ? "R4/R9 data" : "R3/R9 data", out_bit, exp_b);
   endtask

   task automatic run_block(input bit m, input int gap_every, input int kind);
      for (int k = 0; k < 64; k++) begin
         bit b;
         case (kind)
            0: b = 1'($urandom);
            1: b = 1'(k % 2);
            default: b = (k == 5);
         endcase
         if (gap_every > 0 && (k % gap_every) == 0) step(1'b0, 1'b1, m);
         step(1'b1, b, m);
      end
   endtask

   initial begin
      #(200000 * 10);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1; mode = 0; in_valid = 0; in_bit = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", out_valid, 1'b0);
      rst = 0;

      // fill with gaps: no output during the first block (R1, R7)
      run_block(1'b0, 7, 0);
      // back-to-back forward blocks, swap without gaps (R3, R5, R9)
      run_block(1'b0, 0, 1);
      run_block(1'b0, 0, 0);
      run_block(1'b0, 0, 2);
      // inverse blocks with idle cycles (R4, R7)
      run_block(1'b1, 0, 0);
      run_block(1'b1, 3, 0);
      run_block(1'b1, 0, 2);
      // R8: mode 0 through the block, 1 only on the completing bit
      for (int k = 0; k < 63; k++) step(1'b1, 1'($urandom), 1'b0);
      step(1'b1, 1'($urandom), 1'b1);
      run_block(1'b0, 0, 0);
      // R8: opposite case
      for (int k = 0; k < 63; k++) step(1'b1, 1'($urandom), 1'b1);
      step(1'b1, 1'($urandom), 1'b0);
      run_block(1'b1, 5, 0);

      // R1: reset in mid block, then 64 inputs without output
      for (int k = 0; k < 20; k++) step(1'b1, 1'($urandom), 1'b0);
      rst = 1; in_valid = 1;
      @(posedge clk); #1;
      check("R1 reset mid", out_valid, 1'b0);
      rst = 0;
      model_reset();
      run_block(1'b1, 0, 0);
      run_block(1'b0, 0, 0);
      run_block(1'b0, 0, 1);
      step(1'b0, 1'b0, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule